// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

This block is a full-duplex serial transceiver for a point-to-point link that carries no clock. The transmit side takes one word at a time over a valid/ready handshake and shifts it out on a single line. The receive side watches its own line for a falling edge and confirms it half a bit later. It then times every following bit from that edge and samples it at its centre. When the frame is complete it hands the word on, together with a parity flag and a framing flag.

The frame shape is set at run time by plain control inputs: a clock divisor, the data width (5 to 9 bits), the parity mode and one or two stop bits. Both directions count time in ticks of one sixteenth of a bit. One tick lasts `cfg_div` clock cycles, so one bit lasts 16 × `cfg_div` cycles. Each direction has its own tick generator. The transmitter restarts its generator when it accepts a word, and the receiver restarts its generator on the start edge. The control inputs must be held steady while a frame is in flight.

Back-pressure rules. On the transmit side a word moves on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` then stays low until the frame has left, so there is no buffering. On the receive side a word is offered on `rx_data` with `rx_valid`, and it is consumed on an edge where `rx_ready` is also high. The serial line cannot be stalled. A word that finishes while an older one is still unconsumed replaces the older one.

Top module: `uart_xcvr`

## Requirements
- R1: After reset `tx_line` is high, `tx_ready` is high and `rx_valid` is low. While the transmitter is idle, `tx_line` stays high.
- R2: A transmitted frame is one low start bit, then the data bits least significant first, then the parity bit if enabled, then high stop bits. Each bit lasts 16 × `cfg_div` clock cycles, counted from the accepting edge.
- R3: `cfg_nbits` selects 5 to 9 data bits. A value below 5 acts as 5 and a value above 9 acts as 9. Transmit data bits above the selected width are ignored, and received data bits above it read as zero.
- R4: `cfg_par` is encoded as follows: 0 gives no parity bit, 1 gives even parity (the count of ones over data and parity is even), 2 gives odd parity, and 3 acts as 0. `cfg_stop2` = 1 gives two stop bits and 0 gives one.
- R5: A word is accepted on an edge with `tx_valid` and `tx_ready` both high. `tx_ready` is low from that edge until the edge that ends the last stop bit, and it is high again on that edge.
- R6: A low level on `rx_line` starts a frame only if the line is still low half a bit later. A shorter low pulse produces no word.
- R7: The receiver samples each bit at its centre and, after the last stop bit, presents the data on `rx_data` with `rx_valid` high.
- R8: `rx_par_err` is high with a word whose received parity bit does not match the selected mode. It is always low when parity is disabled.
- R9: `rx_frm_err` is high with a word if any stop-bit sample was low.
- R10: `rx_valid` and `rx_data` hold until an edge with `rx_ready` high clears them. A newly completed word overwrites a held word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_div | input | 16 | Clock cycles per sixteenth of a bit (0 acts as 1) |
| cfg_nbits | input | 4 | Data bits per frame |
| cfg_par | input | 2 | Parity mode: 0 none, 1 even, 2 odd, 3 none |
| cfg_stop2 | input | 1 | 1 selects two stop bits |
| tx_data | input | 9 | Word to send, least significant bit first |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmitter can take a word |
| tx_line | output | 1 | Serial output, idles high |
| rx_line | input | 1 | Serial input, asynchronous |
| rx_data | output | 9 | Received word |
| rx_valid | output | 1 | Received word held |
| rx_ready | input | 1 | Consumer takes the received word |
| rx_par_err | output | 1 | Parity mismatch on the held word |
| rx_frm_err | output | 1 | Low stop bit on the held word |

## Verification
The bench builds the block with its default parameters: a 16-bit divisor, 9-bit maximum data width and 16× oversampling. It drives `cfg_div` = 2, so one bit lasts 32 cycles. This keeps every frame to a few hundred cycles while still exercising a divided tick, a half-bit start check and mid-bit sampling. With the full 9-bit width, every run-time width from 5 to 9 and both out-of-range clamps are within reach, as is every combination of parity mode and stop count. The receive stimulus injects bad parity bits, low stop bits, short low glitches and an unconsumed word followed by a second one.

// File: rtl/uart_xcvr_pkg.sv
package uart_xcvr_pkg;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_RSVD = 2'd3
  } par_mode_e;

  typedef enum logic [2:0] {
    RS_IDLE  = 3'd0,
    RS_START = 3'd1,
    RS_DATA  = 3'd2,
    RS_PAR   = 3'd3,
    RS_STOP  = 3'd4
  } rx_state_e;

  function automatic logic par_on(input par_mode_e m);
    return (m == PAR_EVEN) || (m == PAR_ODD);
  endfunction

endpackage

// File: rtl/uart_baud_tick.sv
module uart_baud_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  assign lim  = (div == '0) ? '0 : div - 1'b1;
  assign tick = !clr && (cnt_q >= lim);

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (clr)          cnt_q <= '0;
    else if (cnt_q >= lim) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  // R2: with a divisor above one, ticks are never back to back
  a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (lim != '0 && tick) |=> !tick);

endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import uart_xcvr_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int OVS    = 16,
  localparam int NB_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NB_W-1:0]   nbits,
  input  par_mode_e         par_mode,
  input  logic              stop2,
  input  logic              tick,
  output logic              tick_clr,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              line
);
  localparam int FRM_W = DATA_W + 4;
  localparam int LEN_W = $clog2(FRM_W + 1);
  localparam int OC_W  = $clog2(OVS);

  logic             busy_q;
  logic [FRM_W-1:0] frame_q;
  logic [LEN_W-1:0] left_q;
  logic [OC_W-1:0]  ovs_q;
  logic             accept;
  logic [FRM_W-1:0] load_frame;
  logic [LEN_W-1:0] load_len;
  logic             ones;
  logic             pen;

  assign in_ready = !busy_q;
  assign accept   = in_valid && !busy_q;
  assign tick_clr = accept;
  assign line     = frame_q[0];
  assign pen      = par_on(par_mode);

  always_comb begin
    load_frame    = '1;
    load_frame[0] = 1'b0;
    ones          = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < int'(nbits)) begin
        load_frame[i+1] = in_data[i];
        ones            = ones ^ in_data[i];
      end
    end
    if (pen) load_frame[int'(nbits)+1] = ones ^ (par_mode == PAR_ODD);
    load_len = LEN_W'(int'(nbits) + 2 + int'(pen) + int'(stop2));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      frame_q <= '1;
      left_q  <= '0;
      ovs_q   <= '0;
    end else if (accept) begin
      busy_q  <= 1'b1;
      frame_q <= load_frame;
      left_q  <= load_len;
      ovs_q   <= '0;
    end else if (busy_q && tick) begin
      if (ovs_q == OC_W'(OVS - 1)) begin
        ovs_q   <= '0;
        frame_q <= {1'b1, frame_q[FRM_W-1:1]};
        left_q  <= left_q - 1'b1;
        if (left_q == LEN_W'(1)) busy_q <= 1'b0;
      end else begin
        ovs_q <= ovs_q + 1'b1;
      end
    end
  end

  // R5: an accepted word drops ready and starts the low start bit
  a_r5_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!in_ready && !line));

  // R1: an idle transmitter keeps the line high
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> line);

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_xcvr_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int OVS    = 16,
  localparam int NB_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NB_W-1:0]   nbits,
  input  par_mode_e         par_mode,
  input  logic              stop2,
  input  logic              tick,
  output logic              tick_clr,
  input  logic              line,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_perr,
  output logic              out_ferr
);
  localparam int OC_W = $clog2(OVS);

  logic [1:0]        sync_q;
  logic              s;
  rx_state_e         st_q;
  logic [OC_W-1:0]   ovs_q;
  logic [NB_W-1:0]   idx_q;
  logic [DATA_W-1:0] shreg_q;
  logic              par_q;
  logic              ferr_q;
  logic              stop_idx_q;
  logic              mid_start;
  logic              bit_mid;
  logic              ones;
  logic              exp_par;
  logic              pen;

  assign s         = sync_q[1];
  assign tick_clr  = (st_q == RS_IDLE) && !s;
  assign mid_start = tick && (ovs_q == OC_W'(OVS/2 - 1));
  assign bit_mid   = tick && (ovs_q == OC_W'(OVS - 1));
  assign pen       = par_on(par_mode);

  always_comb begin
    ones = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (i < int'(nbits)) ones = ones ^ shreg_q[i];
    exp_par = ones ^ (par_mode == PAR_ODD);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], line};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= RS_IDLE;
      ovs_q      <= '0;
      idx_q      <= '0;
      shreg_q    <= '0;
      par_q      <= 1'b0;
      ferr_q     <= 1'b0;
      stop_idx_q <= 1'b0;
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_perr   <= 1'b0;
      out_ferr   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      unique case (st_q)
        RS_IDLE: begin
          if (!s) begin
            st_q  <= RS_START;
            ovs_q <= '0;
          end
        end
        RS_START: begin
          if (mid_start) begin
            ovs_q <= '0;
            if (s) begin
              st_q <= RS_IDLE;
            end else begin
              st_q    <= RS_DATA;
              idx_q   <= '0;
              shreg_q <= '0;
              ferr_q  <= 1'b0;
            end
          end else if (tick) begin
            ovs_q <= ovs_q + 1'b1;
          end
        end
        RS_DATA: begin
          if (bit_mid) begin
            ovs_q          <= '0;
            shreg_q[idx_q] <= s;
            if (idx_q == nbits - 1'b1) begin
              st_q       <= pen ? RS_PAR : RS_STOP;
              stop_idx_q <= 1'b0;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end else if (tick) begin
            ovs_q <= ovs_q + 1'b1;
          end
        end
        RS_PAR: begin
          if (bit_mid) begin
            ovs_q <= '0;
            par_q <= s;
            st_q  <= RS_STOP;
          end else if (tick) begin
            ovs_q <= ovs_q + 1'b1;
          end
        end
        RS_STOP: begin
          if (bit_mid) begin
            ovs_q <= '0;
            if (stop2 && !stop_idx_q) begin
              stop_idx_q <= 1'b1;
              ferr_q     <= ferr_q | !s;
            end else begin
              st_q      <= RS_IDLE;
              out_valid <= 1'b1;
              out_data  <= shreg_q;
              out_perr  <= pen && (par_q != exp_par);
              out_ferr  <= ferr_q | !s;
            end
          end else if (tick) begin
            ovs_q <= ovs_q + 1'b1;
          end
        end
        default: st_q <= RS_IDLE;
      endcase
    end
  end

  // R6: a high line keeps the receiver idle
  a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RS_IDLE && s) |=> (st_q == RS_IDLE));

  // R7: a word is only delivered from the stop-bit phase
  a_r7_word_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(st_q) == RS_STOP));

  // R8: no parity error when parity is disabled
  a_r8_no_perr_without_par: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !pen) |-> !out_perr);

endmodule

// File: rtl/uart_xcvr.sv
module uart_xcvr
  import uart_xcvr_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 9,
  parameter int OVS    = 16,
  parameter int MIN_W  = 5,
  localparam int NB_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [NB_W-1:0]   cfg_nbits,
  input  logic [1:0]        cfg_par,
  input  logic              cfg_stop2,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              tx_line,
  input  logic              rx_line,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              rx_par_err,
  output logic              rx_frm_err
);
  localparam logic [NB_W-1:0] MIN_NB = NB_W'(MIN_W);
  localparam logic [NB_W-1:0] MAX_NB = NB_W'(DATA_W);
  localparam int N_DIR = 2;

  logic [NB_W-1:0]   nb_eff;
  par_mode_e         pmode;
  logic [N_DIR-1:0]  tclr;
  logic [N_DIR-1:0]  tick;
  logic              w_valid;
  logic [DATA_W-1:0] w_data;
  logic              w_perr;
  logic              w_ferr;

  assign nb_eff = (cfg_nbits < MIN_NB) ? MIN_NB :
                  (cfg_nbits > MAX_NB) ? MAX_NB : cfg_nbits;
  assign pmode  = par_mode_e'(cfg_par);

  for (genvar g = 0; g < N_DIR; g++) begin : g_tick
    uart_baud_tick #(.DIV_W(DIV_W)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (tclr[g]),
      .div  (cfg_div),
      .tick (tick[g])
    );
  end

  uart_tx_core #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .nbits   (nb_eff),
    .par_mode(pmode),
    .stop2   (cfg_stop2),
    .tick    (tick[0]),
    .tick_clr(tclr[0]),
    .in_data (tx_data),
    .in_valid(tx_valid),
    .in_ready(tx_ready),
    .line    (tx_line)
  );

  uart_rx_core #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .nbits    (nb_eff),
    .par_mode (pmode),
    .stop2    (cfg_stop2),
    .tick     (tick[1]),
    .tick_clr (tclr[1]),
    .line     (rx_line),
    .out_valid(w_valid),
    .out_data (w_data),
    .out_perr (w_perr),
    .out_ferr (w_ferr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_valid   <= 1'b0;
      rx_data    <= '0;
      rx_par_err <= 1'b0;
      rx_frm_err <= 1'b0;
    end else if (w_valid) begin
      rx_valid   <= 1'b1;
      rx_data    <= w_data;
      rx_par_err <= w_perr;
      rx_frm_err <= w_ferr;
    end else if (rx_valid && rx_ready) begin
      rx_valid <= 1'b0;
    end
  end

  // R10: an unconsumed word stays put until a new one arrives
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !w_valid) |=> (rx_valid && $stable(rx_data)));

endmodule

// File: tb/uart_xcvr_tb_top.sv
module uart_xcvr_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 2;
  localparam int BIT_CYC    = 16 * DIV;
  localparam int NVEC       = 8;

  typedef struct packed {
    logic [3:0] nb;
    logic [1:0] par;
    logic       st2;
    logic [8:0] data;
    logic       bad_par;
    logic       bad_stop;
  } vec_t;

  // nb, par (0 none 1 even 2 odd), two stops, data, bad parity, low stop
  localparam vec_t VECS [NVEC] = '{
    '{4'd8, 2'd0, 1'b0, 9'h0A5, 1'b0, 1'b0},
    '{4'd8, 2'd1, 1'b1, 9'h03C, 1'b0, 1'b0},
    '{4'd5, 2'd2, 1'b0, 9'h0F3, 1'b0, 1'b0},
    '{4'd9, 2'd1, 1'b0, 9'h155, 1'b0, 1'b0},
    '{4'd7, 2'd2, 1'b1, 9'h1DA, 1'b0, 1'b0},
    '{4'd8, 2'd1, 1'b0, 9'h00F, 1'b1, 1'b0},
    '{4'd6, 2'd0, 1'b1, 9'h02A, 1'b0, 1'b1},
    '{4'd9, 2'd2, 1'b0, 9'h100, 1'b1, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [15:0] cfg_div = 16'(DIV);
  logic [3:0] cfg_nbits = 4'd8;
  logic [1:0] cfg_par = 2'd0;
  logic       cfg_stop2 = 1'b0;
  logic [8:0] tx_data = '0;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic       tx_line;
  logic       rx_line = 1'b1;
  logic [8:0] rx_data;
  logic       rx_valid;
  logic       rx_ready = 1'b0;
  logic       rx_par_err;
  logic       rx_frm_err;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_xcvr dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_nbits(cfg_nbits),
    .cfg_par(cfg_par), .cfg_stop2(cfg_stop2), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_line(tx_line),
    .rx_line(rx_line), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err)
  );

  task automatic check(input bit ok, input string req, input int got, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  function automatic int eff_width(input logic [3:0] nb);
    return (nb < 4'd5) ? 5 : (nb > 4'd9) ? 9 : int'(nb);
  endfunction

  function automatic logic [8:0] masked(input vec_t v);
    return v.data & (9'h1FF >> (9 - eff_width(v.nb)));
  endfunction

  function automatic int build_frame(input vec_t v, output logic [12:0] f);
    int n; int pos; logic p;
    n = eff_width(v.nb);
    f = '1; f[0] = 1'b0; p = 1'b0;
    for (int i = 0; i < n; i++) begin
      f[1+i] = v.data[i];
      p      = p ^ v.data[i];
    end
    pos = n + 1;
    if (v.par == 2'd1 || v.par == 2'd2) begin
      if (v.par == 2'd2) p = ~p;
      if (v.bad_par)     p = ~p;
      f[pos] = p;
      pos++;
    end
    f[pos] = ~v.bad_stop;
    pos++;
    if (v.st2) begin
      f[pos] = 1'b1;
      pos++;
    end
    return pos;
  endfunction

  task automatic set_cfg(input vec_t v);
    @(negedge clk);
    cfg_nbits = v.nb; cfg_par = v.par; cfg_stop2 = v.st2;
  endtask

  // R2 R3 R4 R5: serialized frame and ready window
  task automatic tx_frame(input vec_t v);
    logic [12:0] f; int len; vec_t g;
    g = v; g.bad_par = 1'b0; g.bad_stop = 1'b0;
    len = build_frame(g, f);
    set_cfg(v);
    tx_data = v.data; tx_valid = 1'b1;
    @(posedge clk); #1;
    tx_valid = 1'b0;
    check(!tx_ready, "R5 ready low after accept", int'(tx_ready), 0);
    repeat (BIT_CYC/2) @(posedge clk);
    #1;
    for (int k = 0; k < len; k++) begin
      check(tx_line == f[k], $sformatf("R2 tx bit %0d", k), int'(tx_line), int'(f[k]));
      check(!tx_ready, "R5 ready low mid-frame", int'(tx_ready), 0);
      if (k < len - 1) begin
        repeat (BIT_CYC) @(posedge clk);
        #1;
      end
    end
    repeat (BIT_CYC/2 - 1) @(posedge clk);
    #1;
    check(!tx_ready, "R5 ready low in last cycle", int'(tx_ready), 0);
    @(posedge clk); #1;
    check(tx_ready, "R5 ready back at frame end", int'(tx_ready), 1);
    check(tx_line, "R1 line idle high", int'(tx_line), 1);
  endtask

  task automatic rx_drive(input vec_t v);
    logic [12:0] f; int len;
    len = build_frame(v, f);
    set_cfg(v);
    for (int k = 0; k < len; k++) begin
      rx_line = f[k];
      repeat (BIT_CYC) @(negedge clk);
    end
    rx_line = 1'b1;
    #1;
  endtask

  // R7 R8 R9: received word and flags
  task automatic rx_frame(input vec_t v, input bit consume);
    bit pen;
    pen = (v.par == 2'd1 || v.par == 2'd2);
    rx_drive(v);
    check(rx_valid, "R7 rx word valid", int'(rx_valid), 1);
    check(rx_data == masked(v), "R7 R3 rx data", int'(rx_data), int'(masked(v)));
    check(rx_par_err == (pen && v.bad_par), "R8 parity flag", int'(rx_par_err), int'(pen && v.bad_par));
    check(rx_frm_err == v.bad_stop, "R9 framing flag", int'(rx_frm_err), int'(v.bad_stop));
    if (consume) begin
      @(negedge clk); rx_ready = 1'b1;
      @(negedge clk); rx_ready = 1'b0;
      check(!rx_valid, "R10 consumed word clears", int'(rx_valid), 0);
      repeat (2*BIT_CYC) @(negedge clk);
      check(!rx_valid, "R6 no spurious word after frame", int'(rx_valid), 0);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired got=1 exp=0");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    vec_t d;
    repeat (4) @(negedge clk);
    check(tx_line, "R1 reset tx_line", int'(tx_line), 1);
    check(tx_ready, "R1 reset tx_ready", int'(tx_ready), 1);
    check(!rx_valid, "R1 reset rx_valid", int'(rx_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      tx_frame(VECS[i]);
      rx_frame(VECS[i], 1'b1);
    end

    // R3: out-of-range widths clamp
    d = '{4'd2, 2'd1, 1'b0, 9'h1E9, 1'b0, 1'b0};
    tx_frame(d);
    rx_frame(d, 1'b1);
    d = '{4'd14, 2'd0, 1'b1, 9'h16B, 1'b0, 1'b0};
    tx_frame(d);
    rx_frame(d, 1'b1);

    // R4: reserved parity code behaves as none
    d = '{4'd8, 2'd3, 1'b0, 9'h081, 1'b0, 1'b0};
    tx_frame(d);
    rx_frame(d, 1'b1);

    // R6: low glitch shorter than half a bit yields no word
    @(negedge clk);
    rx_line = 1'b0;
    repeat (BIT_CYC/4) @(negedge clk);
    rx_line = 1'b1;
    repeat (2*BIT_CYC) @(negedge clk);
    check(!rx_valid, "R6 glitch rejected", int'(rx_valid), 0);

    // R10: hold, then overwrite by a newer word
    d = '{4'd8, 2'd0, 1'b0, 9'h05E, 1'b0, 1'b0};
    rx_frame(d, 1'b0);
    repeat (3*BIT_CYC) @(negedge clk);
    check(rx_valid && rx_data == 9'h05E, "R10 word held without ready", int'(rx_data), 'h05E);
    d = '{4'd8, 2'd0, 1'b0, 9'h0C3, 1'b0, 1'b0};
    rx_frame(d, 1'b0);
    check(rx_data == 9'h0C3, "R10 newer word overwrites", int'(rx_data), 'h0C3);
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
    check(!rx_valid, "R10 overwrite consumed", int'(rx_valid), 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule